// File: doc/BRIEF.md
# Strap-Addressed Register Bank Slave on a Two-Wire Serial Bus

This block is a slave on a two-wire serial bus (I2C-compatible, 7-bit addressing) that gives a host controller access to a small bank of 8-bit control registers. Both bus lines pass through a two-flop synchronizer and a glitch filter running on the system clock. Bus conditions are detected from the filtered levels. The block never drives a line high. It only raises an enable that pulls SDA low.

The bus address is chosen by a three-level strap input. After the address byte, the host writes a register pointer. Writes then stream data bytes from that pointer onward. Reads use a repeated START and return bytes from the pointer onward. The pointer moves forward each time a byte completes. The register contents go out on a flat vector for the rest of the chip. A one-cycle read strobe per address marks each byte the block fetches for transmission.

Writable registers take their reset values from a defaults input. One read-only register mirrors live status bits. Another read-only register collects interrupt events, drives an interrupt output, and clears itself when it is read.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The 7-bit bus address comes from `addr_sel_i`: 2'b01 (strap tied high) selects 0x7F, 2'b00 (tied low) selects 0x7D, and 2'b10 or 2'b11 (floating) selects 0x7C. An address byte that does not match gets no ACK, and the block ignores the bus until the next START.
- R2: A write is START, address with R/W=0, a pointer byte, then any number of data bytes. The slave ACKs each of these bytes. Each data byte goes to the register at the pointer, and the pointer then advances by one.
- R3: A read is a pointer write, then a repeated START with R/W=1. The slave sends the byte at the pointer. On each master ACK it advances the pointer and sends the next byte. A master NACK ends the read.
- R4: Bytes travel MSB first, and the acknowledge occupies the ninth clock. `sda_oe_o`=1 pulls SDA low, and it changes only while the filtered SCL is low.
- R5: A START or STOP seen in the middle of a byte aborts the transfer, and the partial byte is discarded. A START always begins a new address phase.
- R6: Address 0x0A reads the live value of `status_i`. Address 0x0B is read-only. Writes to either address are ACKed but change nothing.
- R7: Register 0x0B ORs in `irq_set_i` every cycle. `irq_o` is high while any bit of 0x0B is set. Fetching 0x0B for a read clears it to 0x00. A set arriving in the same cycle as the clear is kept.
- R8: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect. With 7 cycles at 125 MHz this covers 50 ns.
- R9: Addresses 0x0D to 0xFF read as 0x00. Writes to them are discarded.
- R10: Reset loads `defaults_i` byte i into writable register i and clears 0x0B. `regs_o` byte i shows register i.
- R11: Each byte fetched for transmission pulses the `rd_strobe_o` bit of its address for exactly one cycle. No bit pulses for an address that is never fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Address strap: 00 low, 01 high, 1x floating |
| defaults_i | input | NUM_REGS*8 | Reset values, byte i for register i |
| status_i | input | 8 | Live status bits shown at 0x0A |
| irq_set_i | input | 8 | Interrupt event bits ORed into 0x0B |
| regs_o | output | NUM_REGS*8 | Register contents, byte i for register i |
| rd_strobe_o | output | NUM_REGS | One-cycle pulse per fetched register |
| irq_o | output | 1 | High while 0x0B is non-zero |

## Verification
Every bus edge reaches the protocol engine 2 + `FILT_CYC` system clocks after it occurs on the pin. The engine adds one register before `sda_oe_o`, `regs_o` or `rd_strobe_o` changes. At most about ten cycles therefore separate a bus edge from its result. The bench moves the bus only in quarter-bit steps of 20 cycles. It samples SDA in the middle of the high phase, two quarters after the last change. Register and interrupt checks run only after the closing STOP, or several cycles after an event pulse. The strobe monitor samples on the falling clock edge, inside the one-cycle pulse.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } rb_state_e;

    typedef struct packed {
        rb_state_e  st;
        logic [3:0] bitcnt;
        logic [7:0] shreg;
        logic [7:0] tx;
        logic [7:0] ptr;
        logic       rw;
        logic       mack;
        logic       sda_oe;
        logic       scl_p;
        logic       sda_p;
    } rb_eng_s;

    // strap level to bus address
    function automatic logic [6:0] strap_to_addr(input logic [1:0] sel);
        case (sel)
            2'b01:   strap_to_addr = 7'h7F;
            2'b00:   strap_to_addr = 7'h7D;
            default: strap_to_addr = 7'h7C;
        endcase
    endfunction

endpackage

// File: rtl/i2c_rb_deglitch.sv
module i2c_rb_deglitch #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CNT_W-1:0]       cnt;
        logic                   lvl;
    } flt_s;

    flt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[SYNC_STAGES-2:0], raw_i};
        if (flt_q.sync[SYNC_STAGES-1] != flt_q.lvl) begin
            if (flt_q.cnt == CNT_W'(FILT_CYC - 1)) begin
                flt_d.lvl = flt_q.sync[SYNC_STAGES-1];
                flt_d.cnt = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end else begin
            flt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q.sync <= '1;
            flt_q.cnt  <= '0;
            flt_q.lvl  <= 1'b1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign lvl_o = flt_q.lvl;
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
    import i2c_rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [6:0] dev_addr_i,
    input  logic [7:0] rd_data_i,
    output logic       sda_oe_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       rd_en_o,
    output logic [7:0] rd_addr_o
);
    rb_eng_s eng_d, eng_q;
    logic scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl_i & ~eng_q.scl_p;
    assign scl_fall = ~scl_i & eng_q.scl_p;
    assign start_c  = scl_i & eng_q.scl_p & eng_q.sda_p & ~sda_i;
    assign stop_c   = scl_i & eng_q.scl_p & ~eng_q.sda_p & sda_i;

    // fetch of the next byte to send happens on the ack-closing fall
    assign rd_en_o   = scl_fall && ((eng_q.st == ST_ADDR_ACK && eng_q.rw) ||
                                    (eng_q.st == ST_RACK && eng_q.mack));
    assign rd_addr_o = (eng_q.st == ST_RACK) ? eng_q.ptr + 8'd1 : eng_q.ptr;
    assign wr_addr_o = eng_q.ptr;
    assign wr_data_o = eng_q.shreg;
    assign sda_oe_o  = eng_q.sda_oe;

    always_comb begin
        eng_d       = eng_q;
        eng_d.scl_p = scl_i;
        eng_d.sda_p = sda_i;
        wr_en_o     = 1'b0;
        if (start_c) begin
            eng_d.st     = ST_ADDR;
            eng_d.bitcnt = '0;
            eng_d.sda_oe = 1'b0;
        end else if (stop_c) begin
            eng_d.st     = ST_IDLE;
            eng_d.sda_oe = 1'b0;
        end else begin
            case (eng_q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        eng_d.shreg  = {eng_q.shreg[6:0], sda_i};
                        eng_d.bitcnt = eng_q.bitcnt + 4'd1;
                    end else if (scl_fall && eng_q.bitcnt == 4'd8) begin
                        if (eng_q.st == ST_ADDR) begin
                            if (eng_q.shreg[7:1] == dev_addr_i) begin
                                eng_d.st     = ST_ADDR_ACK;
                                eng_d.sda_oe = 1'b1;
                                eng_d.rw     = eng_q.shreg[0];
                            end else begin
                                eng_d.st = ST_IGNORE;
                            end
                        end else if (eng_q.st == ST_PTR) begin
                            eng_d.ptr    = eng_q.shreg;
                            eng_d.st     = ST_PTR_ACK;
                            eng_d.sda_oe = 1'b1;
                        end else begin
                            wr_en_o      = 1'b1;
                            eng_d.ptr    = eng_q.ptr + 8'd1;
                            eng_d.st     = ST_WDATA_ACK;
                            eng_d.sda_oe = 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        eng_d.bitcnt = '0;
                        if (eng_q.rw) begin
                            eng_d.st     = ST_RDATA;
                            eng_d.sda_oe = ~rd_data_i[7];
                            eng_d.tx     = {rd_data_i[6:0], 1'b0};
                        end else begin
                            eng_d.st     = ST_PTR;
                            eng_d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        eng_d.st     = ST_WDATA;
                        eng_d.sda_oe = 1'b0;
                        eng_d.bitcnt = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        eng_d.bitcnt = eng_q.bitcnt + 4'd1;
                    end else if (scl_fall) begin
                        if (eng_q.bitcnt == 4'd8) begin
                            eng_d.sda_oe = 1'b0;
                            eng_d.st     = ST_RACK;
                        end else begin
                            eng_d.sda_oe = ~eng_q.tx[7];
                            eng_d.tx     = {eng_q.tx[6:0], 1'b0};
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        eng_d.mack = ~sda_i;
                    end else if (scl_fall) begin
                        if (eng_q.mack) begin
                            eng_d.ptr    = eng_q.ptr + 8'd1;
                            eng_d.st     = ST_RDATA;
                            eng_d.bitcnt = '0;
                            eng_d.sda_oe = ~rd_data_i[7];
                            eng_d.tx     = {rd_data_i[6:0], 1'b0};
                        end else begin
                            eng_d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q        <= '0;
            eng_q.st     <= ST_IDLE;
            eng_q.scl_p  <= 1'b1;
            eng_q.sda_p  <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
    parameter int NUM_REGS = 13,
    parameter int STAT_IDX = 10,
    parameter int INT_IDX  = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_REGS*8-1:0] defaults_i,
    input  logic [7:0]            status_i,
    input  logic [7:0]            irq_set_i,
    input  logic                  wr_en_i,
    input  logic [7:0]            wr_addr_i,
    input  logic [7:0]            wr_data_i,
    input  logic                  rd_en_i,
    input  logic [7:0]            rd_addr_i,
    output logic [7:0]            rd_data_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   rd_strobe_o,
    output logic                  irq_o
);
    logic [7:0] view [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign rd_strobe_o[i] = rd_en_i && (rd_addr_i == 8'(i));
        assign regs_o[8*i +: 8] = view[i];
        if (i == STAT_IDX) begin : g_stat
            logic unused_stat_dflt;
            assign unused_stat_dflt = ^defaults_i[8*i +: 8];
            assign view[i] = status_i;
        end else if (i == INT_IDX) begin : g_int
            logic [7:0] int_d, int_q;
            logic unused_int_dflt;
            assign unused_int_dflt = ^defaults_i[8*i +: 8];
            always_comb begin
                int_d = rd_strobe_o[i] ? 8'h00 : int_q;
                int_d = int_d | irq_set_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) int_q <= 8'h00;
                else        int_q <= int_d;
            end
            assign view[i] = int_q;
            assign irq_o   = |int_q;
        end else begin : g_rw
            logic [7:0] reg_d, reg_q;
            always_comb begin
                reg_d = reg_q;
                if (wr_en_i && wr_addr_i == 8'(i)) reg_d = wr_data_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) reg_q <= defaults_i[8*i +: 8];
                else        reg_q <= reg_d;
            end
            assign view[i] = reg_q;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr_i == 8'(i)) rd_data_o = view[i];
        end
    end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS    = 13,
    parameter int STAT_IDX    = 10,
    parameter int INT_IDX     = 11,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [1:0]            addr_sel_i,
    input  logic [NUM_REGS*8-1:0] defaults_i,
    input  logic [7:0]            status_i,
    input  logic [7:0]            irq_set_i,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic [NUM_REGS-1:0]   rd_strobe_o,
    output logic                  irq_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] line_raw, line_flt;
    logic       scl_flt, sda_flt;
    logic       wr_en, rd_en;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [6:0] dev_addr;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2c_rb_deglitch #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(line_raw[g]),
            .lvl_o(line_flt[g])
        );
    end

    assign scl_flt  = line_flt[1];
    assign sda_flt  = line_flt[0];
    assign dev_addr = strap_to_addr(addr_sel_i);

    i2c_rb_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_flt),
        .sda_i     (sda_flt),
        .dev_addr_i(dev_addr),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe_o),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr)
    );

    i2c_rb_regfile #(
        .NUM_REGS(NUM_REGS),
        .STAT_IDX(STAT_IDX),
        .INT_IDX (INT_IDX)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .defaults_i (defaults_i),
        .status_i   (status_i),
        .irq_set_i  (irq_set_i),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .regs_o     (regs_o),
        .rd_strobe_o(rd_strobe_o),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk #(
    parameter int NUM_REGS = 13,
    parameter int INT_IDX  = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_flt,
    input logic                  sda_oe,
    input logic [NUM_REGS-1:0]   rd_strobe,
    input logic [7:0]            irq_set,
    input logic                  irq,
    input logic [NUM_REGS*8-1:0] regs
);
    logic [7:0] int_byte;
    assign int_byte = regs[8*INT_IDX +: 8];

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_flt); // R4
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_strobe)); // R11
    AST_INT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe[INT_IDX] && irq_set == 8'h00) |=> (int_byte == 8'h00)); // R7
    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe[INT_IDX] && irq_set == 8'h00) |=> $stable(int_byte)); // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_set != 8'h00)); // R7
endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk #(
    .NUM_REGS(NUM_REGS),
    .INT_IDX (INT_IDX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_flt  (scl_flt),
    .sda_oe   (sda_oe_o),
    .rd_strobe(rd_strobe_o),
    .irq_set  (irq_set_i),
    .irq      (irq_o),
    .regs     (regs_o)
);

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
    localparam int NR = 13;
    localparam int Q  = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, glitch_scl = 1'b0, glitch_sda = 1'b0;
    logic scl_line, sda_line, sda_oe, irq;
    logic [1:0] strap = 2'b01;
    logic [NR*8-1:0] dflt, regs;
    logic [7:0] status = 8'h96, irq_set = 8'h00;
    logic [NR-1:0] strobe;
    logic clr_cnt = 1'b1;
    int strobe_cnt [NR];
    int n_chk = 0, n_fail = 0;

    assign scl_line = scl_m | glitch_scl;
    assign sda_line = sda_m & ~glitch_sda & ~sda_oe;

    i2c_regbank_slave u_i2c_regbank_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(strap), .defaults_i(dflt),
        .status_i(status), .irq_set_i(irq_set), .regs_o(regs),
        .rd_strobe_o(strobe), .irq_o(irq)
    );

    always @(negedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (clr_cnt) strobe_cnt[i] = 0;
            else if (strobe[i]) strobe_cnt[i] = strobe_cnt[i] + 1;
        end
    end

    // ptr, write data, expected readback
    localparam logic [23:0] VEC [6] = '{
        24'h00A5A5, 24'h053C3C, 24'h0CFFFF,
        24'h0A5596, 24'h0D7700, 24'h0F1200
    };

    function automatic logic [7:0] dbyte(input int i);
        return 8'(8'h30 + 7 * i);
    endfunction

    function automatic logic [7:0] rbyte(input int i);
        return regs[8*i +: 8];
    endfunction

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic start_c;
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic stop_c;
        sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    // mode 1: SDA spike while SCL high, mode 2: SCL spike while SCL low
    task automatic send_bit(input logic b, input int mode);
        sda_m = b; wt(Q/2);
        if (mode == 2) begin glitch_scl = 1'b1; wt(4); glitch_scl = 1'b0; end else wt(4);
        wt(Q/2 - 4); scl_m = 1'b1; wt(Q/2);
        if (mode == 1) begin glitch_sda = 1'b1; wt(4); glitch_sda = 1'b0; end else wt(4);
        wt(3*Q/2 - 4); scl_m = 1'b0; wt(Q);
    endtask

    task automatic read_bit(output logic b);
        sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); b = sda_line; wt(Q); scl_m = 1'b0; wt(Q);
    endtask

    task automatic tx_byte(input logic [7:0] v, output logic ack_n);
        for (int i = 7; i >= 0; i--) send_bit(v[i], 0);
        read_bit(ack_n);
    endtask

    task automatic rx_byte(output logic [7:0] v, input logic mack);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
        send_bit(~mack, 0);
    endtask

    task automatic write1(input logic [6:0] a, input logic [7:0] ptr, input logic [7:0] v, output logic any_nack);
        logic k0, k1, k2;
        start_c; tx_byte({a, 1'b0}, k0); tx_byte(ptr, k1); tx_byte(v, k2); stop_c;
        any_nack = k0 | k1 | k2;
    endtask

    task automatic read1(input logic [6:0] a, input logic [7:0] ptr, output logic [7:0] v);
        logic k;
        start_c; tx_byte({a, 1'b0}, k); tx_byte(ptr, k);
        start_c; tx_byte({a, 1'b1}, k); rx_byte(v, 1'b0); stop_c;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic k, k1, k2;
        logic [7:0] v;
        for (int i = 0; i < NR; i++) dflt[8*i +: 8] = dbyte(i);
        wt(5); rst_n = 1'b1; wt(5);

        // R10 reset state
        check("R10", rbyte(0), dbyte(0), "default reg0");
        check("R10", rbyte(9), dbyte(9), "default reg9");
        check("R10", rbyte(11), 8'h00, "int reg after reset");
        check("R10", {7'd0, sda_oe}, 8'h00, "sda released");
        check("R7", {7'd0, irq}, 8'h00, "irq low after reset");

        // vector table: single write then readback
        for (int n = 0; n < 6; n++) begin
            logic [7:0] p, w, e;
            string rq;
            {p, w, e} = VEC[n];
            rq = (p == 8'h0A) ? "R6" : ((p > 8'h0C) ? "R9" : "R2");
            write1(7'h7F, p, w, k);
            check(rq, {7'd0, k}, 8'h00, "write acked");
            read1(7'h7F, p, v);
            check(rq, v, e, "readback");
        end
        check("R3", rbyte(5), 8'h3C, "reg5 exported");

        // R1 strap decode and mismatch
        start_c; tx_byte({7'h7C, 1'b0}, k); tx_byte(8'h01, k1); tx_byte(8'hEE, k2); stop_c;
        check("R1", {5'd0, k, k1, k2}, 8'h07, "no ack for foreign address");
        check("R1", rbyte(1), dbyte(1), "reg1 untouched by foreign address");
        strap = 2'b10;
        write1(7'h7C, 8'h01, 8'h5A, k);
        check("R1", {7'd0, k}, 8'h00, "floating strap ack");
        check("R1", rbyte(1), 8'h5A, "floating strap write");
        strap = 2'b00;
        write1(7'h7D, 8'h01, 8'h6B, k);
        check("R1", rbyte(1), 8'h6B, "low strap write");
        strap = 2'b01;

        // R2 / R4 multi-byte write, MSB first, ninth-clock ack
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h02, k);
        tx_byte(8'h11, k); tx_byte(8'h22, k1); tx_byte(8'h34, k2); stop_c;
        check("R4", {5'd0, k, k1, k2}, 8'h00, "data acks in ninth clock");
        check("R4", rbyte(2), 8'h11, "msb-first reg2");
        check("R2", rbyte(3), 8'h22, "pointer advance reg3");
        check("R2", rbyte(4), 8'h34, "pointer advance reg4");

        // R3 / R11 multi-byte read
        clr_cnt = 1'b1; wt(2); clr_cnt = 1'b0;
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h02, k);
        start_c; tx_byte({7'h7F, 1'b1}, k);
        rx_byte(v, 1'b1); check("R3", v, 8'h11, "burst byte0");
        rx_byte(v, 1'b1); check("R3", v, 8'h22, "burst byte1");
        rx_byte(v, 1'b0); check("R3", v, 8'h34, "burst byte2");
        stop_c;
        check("R11", 8'(strobe_cnt[2]), 8'd1, "strobe reg2");
        check("R11", 8'(strobe_cnt[4]), 8'd1, "strobe reg4");
        check("R11", 8'(strobe_cnt[5]), 8'd0, "no strobe after nack");

        // R7 / R6 interrupt register
        irq_set = 8'h05; wt(1); irq_set = 8'h00; wt(3);
        check("R7", {7'd0, irq}, 8'h01, "irq raised");
        check("R7", rbyte(11), 8'h05, "int bits latched");
        write1(7'h7F, 8'h0B, 8'hFF, k);
        check("R6", rbyte(11), 8'h05, "int reg ignores writes");
        read1(7'h7F, 8'h0B, v);
        check("R7", v, 8'h05, "int read value");
        check("R7", rbyte(11), 8'h00, "int cleared by read");
        check("R7", {7'd0, irq}, 8'h00, "irq released");

        // R5 abort by STOP and by repeated START
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h06, k);
        for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
        stop_c;
        check("R5", rbyte(6), dbyte(6), "stop aborts partial byte");
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h07, k);
        for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h06, k); tx_byte(8'h42, k); stop_c;
        check("R5", rbyte(7), dbyte(7), "restart aborts partial byte");
        check("R5", rbyte(6), 8'h42, "new transfer after restart");

        // R8 glitch suppression
        wt(Q); glitch_sda = 1'b1; wt(4); glitch_sda = 1'b0; wt(2*Q);
        check("R8", {7'd0, sda_oe}, 8'h00, "idle glitch ignored");
        start_c; tx_byte({7'h7F, 1'b0}, k); tx_byte(8'h08, k);
        for (int i = 7; i >= 0; i--) send_bit(v[0] | 1'b1 ? (8'hC3 >> i) & 1'b1 : 1'b0, (i == 7) ? 1 : ((i == 4) ? 2 : 0));
        read_bit(k); stop_c;
        check("R8", {7'd0, k}, 8'h00, "glitched byte acked");
        check("R8", rbyte(8), 8'hC3, "glitched byte value");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule